// File: doc/BRIEF.md
# Four-Bit Lookahead-Carry ALU

This block is a purely combinational arithmetic and logic unit for two 4-bit operands. A 4-bit function code `func` drives it. The two upper function bits condition the operands once, at the top of the datapath:

- `func[3]` inverts operand A.
- `func[2]` inverts operand B and also supplies the carry into bit 0.

Together these turn addition into subtraction and AND into NOR.

The conditioned operands feed two things:

- **A shared carry-lookahead network.** It forms every bit carry in two-level sum-of-products form, with no ripple path.
- **A row of identical bit slices.** Each slice forms AND, OR and a three-input XOR sum, and picks one of them with `func[1:0]`.

For set-less-than, bit 0 of the result is replaced by the sum bit of the most significant slice. The upper result bits are forced to zero.

Alongside the result the block reports four condition flags: carry, overflow, negative and zero. A surrounding datapath uses them for branch decisions and compare operations.

Top module: `alu4_lookahead`

## Requirements
- R1: With `func[1:0]` = 00 the result is A' AND B'. Here A' is A inverted when `func[3]`=1, and B' is B inverted when `func[2]`=1.
- R2: With `func[1:0]` = 01 the result is A' OR B'.
- R3: With `func[1:0]` = 10 the result is the low 4 bits of A' + B' + `func[2]`, so `func` = 0110 yields A - B.
- R4: With `func[1:0]` = 11 the result has its upper three bits at zero. Its bit 0 equals bit 3 of A' + B' + `func[2]`, so `func` = 0111 yields 1 exactly when bit 3 of A - B is 1.
- R5: The carry flag is the carry out of bit 3 of A' + B' + `func[2]`, whatever `func[1:0]` is.
- R6: The overflow flag is the carry into bit 3 XOR the carry out of bit 3 of that same addition.
- R7: The negative flag equals bit 3 of the result.
- R8: The zero flag is 1 exactly when all four result bits are 0.
- R9: The flags appear on `flags` as bit 3 = carry, bit 2 = overflow, bit 1 = negative, bit 0 = zero.
- R10: Both outputs depend only on the present inputs. A change of input is visible on the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 4 | Operand A |
| opB | input | 4 | Operand B |
| func | input | 4 | Function code: [3] invert A, [2] negate B, [1:0] operation select |
| result | output | 4 | Operation result |
| flags | output | 4 | Condition flags {carry, overflow, negative, zero} |

## Verification
Every one of the 16 function codes is applied across all 256 operand pairs. Each result is compared with an integer model of the inverted or negated operands. This separates the four slice selections from one another and shows that inversion of each operand is applied on its own path.

A fixed table adds hand-worked cases:
- an add that wraps to zero, which tells carry apart from overflow;
- a signed-overflowing add and subtract;
- an add of 1 and F;
- a set-less-than of F against 0, where overflow is absent but the top sum bit is set;
- a NOR, where the adder flags still follow the inverted operands.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

  // Operation select carried in the low function bits
  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_SUM = 2'b10,
    OP_SLT = 2'b11
  } aluOp_t;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic   invA;
    logic   negB;
    aluOp_t op;
    logic   sltOverride;
  } aluCtrl_t;

endpackage

// File: rtl/alu4_ctrl.sv
module alu4_ctrl
  import alu4_pkg::*;
(
  input  logic [3:0] func,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl.invA        = func[3];
    ctrl.negB        = func[2];
    ctrl.op          = aluOp_t'(func[1:0]);
    ctrl.sltOverride = (func[1:0] == 2'b11);
  end

endmodule

// File: rtl/alu4_cla.sv
module alu4_cla #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             carryIn,
  output logic [WIDTH:0]   carries
);

  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] prop;

  assign gen  = aIn & bIn;
  assign prop = aIn | bIn;

  // Each carry is an OR of product terms (two-level), no slice-to-slice ripple
  always_comb begin
    logic term;
    carries    = '0;
    carries[0] = carryIn;
    for (int i = 1; i <= WIDTH; i++) begin
      term = carryIn;
      for (int k = 0; k < i; k++) term = term & prop[k];
      carries[i] = term;
      for (int j = 0; j < i; j++) begin
        term = gen[j];
        for (int k = j + 1; k < i; k++) term = term & prop[k];
        carries[i] = carries[i] | term;
      end
    end
  end

endmodule

// File: rtl/alu4_slice.sv
module alu4_slice
  import alu4_pkg::*;
(
  input  logic   aBit,
  input  logic   bBit,
  input  logic   cin,
  input  aluOp_t op,
  output logic   res,
  output logic   sum
);

  logic halfSum;

  assign halfSum = aBit ^ bBit;
  assign sum     = halfSum ^ cin;

  always_comb begin
    unique case (op)
      OP_AND:  res = aBit & bBit;
      OP_OR:   res = aBit | bBit;
      OP_SUM:  res = sum;
      default: res = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu4_datapath.sv
module alu4_datapath
  import alu4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flags
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] aMod;
  logic [WIDTH-1:0] bMod;
  logic [WIDTH:0]   carries;
  logic [WIDTH-1:0] sliceRes;
  logic [WIDTH-1:0] sliceSum;
  logic             carryFlag;
  logic             ovfFlag;
  logic             negFlag;
  logic             zeroFlag;

  assign aMod = opA ^ {WIDTH{ctrl.invA}};
  assign bMod = opB ^ {WIDTH{ctrl.negB}};

  alu4_cla #(.WIDTH(WIDTH)) cla_i (
    .aIn     (aMod),
    .bIn     (bMod),
    .carryIn (ctrl.negB),
    .carries (carries)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu4_slice slice_i (
      .aBit (aMod[i]),
      .bBit (bMod[i]),
      .cin  (carries[i]),
      .op   (ctrl.op),
      .res  (sliceRes[i]),
      .sum  (sliceSum[i])
    );
  end

  // Gate-level 2:1 select for bit 0
  assign result[0]     = (ctrl.sltOverride & sliceSum[MSB]) | (~ctrl.sltOverride & sliceRes[0]);
  assign result[MSB:1] = sliceRes[MSB:1];

  assign carryFlag = carries[WIDTH];
  assign ovfFlag   = carries[MSB] ^ carries[WIDTH];
  assign negFlag   = result[MSB];
  assign zeroFlag  = ~|result;
  assign flags     = {carryFlag, ovfFlag, negFlag, zeroFlag};

  // Assertions next to the logic they guard
  always_comb begin
    // Lookahead carries and slice sums must agree with a plain addition
    p_cla_matches_add_r5: assert ({carries[WIDTH], sliceSum} ==
                                  ({1'b0, aMod} + {1'b0, bMod} + (WIDTH+1)'(ctrl.negB)));
    // Overflow only when same-sign operands give a sum of the other sign
    p_no_overflow_r6: assert (!ovfFlag ||
                              ((aMod[MSB] == bMod[MSB]) && (sliceSum[MSB] != aMod[MSB])));
    // Set-less-than leaves the upper result bits clear
    p_slt_upper_zero_r4: assert (!(ctrl.op == OP_SLT) || (result[MSB:1] == '0));
    // Sum selection passes the slice sums through unchanged
    p_sum_passthrough_r3: assert (!(ctrl.op == OP_SUM) || (result == sliceSum));
  end

endmodule

// File: rtl/alu4_lookahead.sv
module alu4_lookahead
  import alu4_pkg::*;
(
  input  logic [3:0] opA,
  input  logic [3:0] opB,
  input  logic [3:0] func,
  output logic [3:0] result,
  output logic [3:0] flags
);

  aluCtrl_t ctrl;

  alu4_ctrl ctrl_i (
    .func (func),
    .ctrl (ctrl)
  );

  alu4_datapath #(.WIDTH(4)) dp_i (
    .opA    (opA),
    .opB    (opB),
    .ctrl   (ctrl),
    .result (result),
    .flags  (flags)
  );

endmodule

// File: tb/alu4_lookahead_tb.sv
module alu4_lookahead_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 10;

  // Each entry: {A, B, func, flags, result}
  localparam logic [19:0] VEC [NVEC] = '{
    20'h0_0_1_1_0,
    20'h1_F_6_0_2,
    20'hF_0_7_8_1,
    20'h7_1_2_6_8,
    20'hC_A_0_E_8,
    20'h5_A_1_2_F,
    20'hF_1_2_9_0,
    20'h8_1_6_C_7,
    20'h3_5_7_0_1,
    20'h0_0_C_A_F
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] opA = '0;
  logic [3:0] opB = '0;
  logic [3:0] func = '0;
  logic [3:0] result;
  logic [3:0] flags;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu4_lookahead dut_i (
    .opA    (opA),
    .opB    (opB),
    .func   (func),
    .result (result),
    .flags  (flags)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h (A=%h B=%h f=%h)", req, act, exp, opA, opB, func);
    end
  endtask

  // Independent integer model
  task automatic model(input logic [3:0] a, input logic [3:0] b, input logic [3:0] f,
                       output logic [3:0] expRes, output logic [3:0] expFlags);
    int am, bm, s, sLow;
    logic c, v;
    am = f[3] ? (15 - int'(a)) : int'(a);
    bm = f[2] ? (15 - int'(b)) : int'(b);
    s  = am + bm + int'(f[2]);
    c  = (s >= 16);
    sLow = s % 16;
    v  = ((am >= 8) == (bm >= 8)) && ((sLow >= 8) != (am >= 8));
    case (f[1:0])
      2'b00: expRes = 4'(am) & 4'(bm);
      2'b01: expRes = 4'(am) | 4'(bm);
      2'b10: expRes = 4'(sLow);
      default: expRes = {3'b000, (sLow >= 8)};
    endcase
    expFlags = {c, v, expRes[3], (expRes == 4'h0)};
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [3:0] er, ef;
    // Reset state: zero inputs give AND of zeros with zero flag (R1, R8)
    repeat (2) @(negedge clk);
    check("R1 reset result", result, 4'h0);
    check("R8 reset flags", flags, 4'h1);
    rstN = 1'b1;

    // Table of hand-worked vectors (R3 R4 R5 R6 R9)
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      opA  = VEC[i][19:16];
      opB  = VEC[i][15:12];
      func = VEC[i][11:8];
      #1;
      check("R9 table flags", flags, VEC[i][7:4]);
      check("R3 table result", result, VEC[i][3:0]);
    end

    // Exhaustive sweep of every function code and operand pair
    for (int f = 0; f < 16; f++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          opA = 4'(a); opB = 4'(b); func = 4'(f);
          #1;
          model(opA, opB, func, er, ef);
          case (func[1:0])
            2'b00: check("R1 and", result, er);
            2'b01: check("R2 or", result, er);
            2'b10: check("R3 sum", result, er);
            default: check("R4 slt", result, er);
          endcase
          check("R5 carry", {3'b000, flags[3]}, {3'b000, ef[3]});
          check("R6 overflow", {3'b000, flags[2]}, {3'b000, ef[2]});
          check("R7 negative", {3'b000, flags[1]}, {3'b000, ef[1]});
          check("R8 zero", {3'b000, flags[0]}, {3'b000, ef[0]});
        end
      end
      @(negedge clk);
    end

    // Combinational response between clock edges (R10)
    @(posedge clk);
    #2;
    opA = 4'h2; opB = 4'h3; func = 4'h2;
    #1;
    check("R10 mid-cycle result", result, 4'h5);
    opA = 4'h9;
    #1;
    check("R10 mid-cycle follow", result, 4'hC);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule